// File: doc/BRIEF.md
# Thermal Clock-Throttling Stop-Clock Generator

This block halts a processor for part of every throttle cycle while throttling is active. It drives an active-low stop-clock output. Throttling has two sources. The first is an external thermal-detect pin. It counts only while hardware throttling is enabled and the pin is not set up as a plain general-purpose input. The second is a software throttle request, which acts on its own. While either source is active, the block counts slots of a fixed length. Sixteen slots make one throttle cycle. Stop-clock is held low for the first N slots of each cycle, where N is a 4-bit duty field.

The slot length comes from a base tick strobe and a timebase select bit. With the select at 0, a slot is `FINE_TICKS` ticks long; with a 1 us tick the default gives 32 us slots in a 512 us cycle. With the select at 1, a slot is `COARSE_TICKS` ticks long; the default gives 1 ms slots in a 16 ms cycle. The duty field and the timebase select are captured when throttling begins and again at each cycle wrap, so a change made during a cycle does not disturb that cycle.

The control is one state machine with three states. The states are `TT_IDLE` (not throttling), `TT_HALT` (stop-clock asserted) and `TT_RUN` (processor running inside a throttle cycle). The transitions are:
- ENTER: `TT_IDLE` to `TT_HALT` or `TT_RUN`, chosen by the captured duty.
- ADVANCE: `TT_HALT` to `TT_RUN` at the end of slot N-1.
- WRAP: back to `TT_HALT` or `TT_RUN` at the end of slot 15, with fresh settings captured.
- EXIT: any state to `TT_IDLE` when neither source is active.

Top module: `thermal_throttle_gen`

## Requirements
- R1: On the first clock edge at which throttling is active while the block is idle, the duty and timebase inputs are captured and a new cycle starts at slot 0. If the captured duty is nonzero, `stpclk_no` goes low after that same edge.
- R2: Inside a cycle, `stpclk_no` is low during slots 0 to N-1 and high during slots N to 15, where N is the captured duty value (unsigned, 4 bits).
- R3: With a captured duty of 0, `stpclk_no` stays high for the whole cycle.
- R4: While `therm_gpi_i` is 1, the thermal pin has no effect on `throttle_active_o` or `stpclk_no`.
- R5: While `therm_en_i` is 0, the thermal pin has no effect on `throttle_active_o` or `stpclk_no`.
- R6: With a captured `coarse_sel_i` of 0, a slot ends on every `FINE_TICKS`-th tick counted after entry. With a captured value of 1, it ends on every `COARSE_TICKS`-th tick.
- R7: A change to `duty_i` or `coarse_sel_i` during a cycle takes effect only at the next wrap from slot 15 to slot 0.
- R8: `sw_req_i` at 1 makes throttling active whatever the thermal pin, `therm_en_i` and `therm_gpi_i` are.
- R9: On the first edge at which throttling is inactive, the block returns to idle. `stpclk_no` is high after that edge, and the slot and tick counts are cleared, so a later activation starts a fresh cycle.
- R10: `throttle_active_o` is 1 exactly when `sw_req_i` is 1, or when the synchronized thermal pin is 1 with `therm_en_i` at 1 and `therm_gpi_i` at 0. After reset it is 0 and `stpclk_no` is 1.
- R11: The thermal pin passes through a two-flop synchronizer, so `throttle_active_o` follows a change on `therm_i` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base time strobe, one clock wide |
| therm_i | input | 1 | Asynchronous thermal-detect pin, active high |
| therm_gpi_i | input | 1 | 1 = thermal pin used as general-purpose input only |
| therm_en_i | input | 1 | Hardware (thermal) throttling enable |
| sw_req_i | input | 1 | Software throttle request |
| coarse_sel_i | input | 1 | Timebase: 0 = fine slots, 1 = coarse slots |
| duty_i | input | DUTY_W | Number of halted slots per cycle |
| stpclk_no | output | 1 | Stop-clock to the processor, active low |
| throttle_active_o | output | 1 | Throttling active status |

## Verification
- **State and stop-clock:** every result except the synchronizer path is due right after the clock edge that sees the causing input. The state register, and through it `stpclk_no`, changes on the edge where the activation or the last tick of a slot is sampled.
- **Thermal path:** `throttle_active_o` reacts to `sw_req_i` and the enables within the same cycle. It reacts to `therm_i` only after two edges.
- **How the bench samples:** a driver applies inputs shortly after each falling edge. Just after the next rising edge it pushes the outputs expected from a requirement-level model into a queue. A monitor pops that entry at the following falling edge, so every comparison falls half a period after the edge that is meant to change the output.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        TT_IDLE = 2'd0,
        TT_HALT = 2'd1,
        TT_RUN  = 2'd2
    } tt_state_e;

    function automatic int unsigned tt_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tt_slot_timer.sv
module tt_slot_timer #(
    parameter int unsigned FINE_TICKS   = 32,
    parameter int unsigned COARSE_TICKS = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic tick_i,
    input  logic coarse_i,
    output logic slot_end_o
);

    localparam int unsigned MAX_TICKS = tt_pkg::tt_max(FINE_TICKS, COARSE_TICKS);
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] FINE_LAST   = CNT_W'(FINE_TICKS - 1);
    localparam logic [CNT_W-1:0] COARSE_LAST = CNT_W'(COARSE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;
    logic             at_last;

    assign last_val   = coarse_i ? COARSE_LAST : FINE_LAST;
    assign at_last    = (cnt_q == last_val);
    assign slot_end_o = tick_i && !clear_i && at_last;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tt_cycle_fsm.sv
module tt_cycle_fsm
    import tt_pkg::*;
#(
    parameter int unsigned DUTY_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              active_i,
    input  logic              slot_end_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              coarse_i,
    output logic              coarse_o,
    output logic              timer_clear_o,
    output logic              stpclk_no
);

    localparam int unsigned SLOTS = 2 ** DUTY_W;
    localparam logic [DUTY_W-1:0] LAST_SLOT = DUTY_W'(SLOTS - 1);

    tt_state_e         state_q, state_d;
    logic [DUTY_W-1:0] slot_q, slot_d;
    logic [DUTY_W-1:0] duty_q, duty_d;
    logic              coarse_q, coarse_d;
    logic [DUTY_W:0]   slot_inc;

    assign slot_inc = {1'b0, slot_q} + (DUTY_W + 1)'(1);

    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q;
        duty_d   = duty_q;
        coarse_d = coarse_q;
        if (!active_i) begin
            // EXIT
            state_d = TT_IDLE;
            slot_d  = '0;
        end else begin
            unique case (state_q)
                TT_IDLE: begin
                    // ENTER
                    slot_d   = '0;
                    duty_d   = duty_i;
                    coarse_d = coarse_i;
                    state_d  = (duty_i != '0) ? TT_HALT : TT_RUN;
                end
                TT_HALT, TT_RUN: begin
                    if (slot_end_i) begin
                        if (slot_q == LAST_SLOT) begin
                            // WRAP
                            slot_d   = '0;
                            duty_d   = duty_i;
                            coarse_d = coarse_i;
                            state_d  = (duty_i != '0) ? TT_HALT : TT_RUN;
                        end else begin
                            // ADVANCE
                            slot_d  = slot_inc[DUTY_W-1:0];
                            state_d = (slot_inc < {1'b0, duty_q}) ? TT_HALT : TT_RUN;
                        end
                    end
                end
                default: begin
                    state_d = TT_IDLE;
                    slot_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= TT_IDLE;
            slot_q   <= '0;
            duty_q   <= '0;
            coarse_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            slot_q   <= slot_d;
            duty_q   <= duty_d;
            coarse_q <= coarse_d;
        end
    end

    always_comb begin
        stpclk_no     = 1'b1;
        timer_clear_o = 1'b1;
        unique case (state_q)
            TT_IDLE: begin
                stpclk_no     = 1'b1;
                timer_clear_o = 1'b1;
            end
            TT_HALT: begin
                stpclk_no     = 1'b0;
                timer_clear_o = !active_i;
            end
            TT_RUN: begin
                stpclk_no     = 1'b1;
                timer_clear_o = !active_i;
            end
            default: begin
                stpclk_no     = 1'b1;
                timer_clear_o = 1'b1;
            end
        endcase
    end

    assign coarse_o = coarse_q;

endmodule

// File: rtl/thermal_throttle_gen.sv
module thermal_throttle_gen #(
    parameter int unsigned DUTY_W       = 4,
    parameter int unsigned FINE_TICKS   = 32,
    parameter int unsigned COARSE_TICKS = 1000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              therm_i,
    input  logic              therm_gpi_i,
    input  logic              therm_en_i,
    input  logic              sw_req_i,
    input  logic              coarse_sel_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              stpclk_no,
    output logic              throttle_active_o
);

    logic therm_sync;
    logic hw_active;
    logic active;
    logic slot_end;
    logic coarse_cur;
    logic timer_clear;

    tt_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (therm_i),
        .sync_o  (therm_sync)
    );

    assign hw_active         = therm_sync && therm_en_i && !therm_gpi_i;
    assign active            = hw_active || sw_req_i;
    assign throttle_active_o = active;

    tt_slot_timer #(
        .FINE_TICKS   (FINE_TICKS),
        .COARSE_TICKS (COARSE_TICKS)
    ) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (timer_clear),
        .tick_i     (tick_i),
        .coarse_i   (coarse_cur),
        .slot_end_o (slot_end)
    );

    tt_cycle_fsm #(
        .DUTY_W (DUTY_W)
    ) i_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .active_i      (active),
        .slot_end_i    (slot_end),
        .duty_i        (duty_i),
        .coarse_i      (coarse_sel_i),
        .coarse_o      (coarse_cur),
        .timer_clear_o (timer_clear),
        .stpclk_no     (stpclk_no)
    );

endmodule

// File: rtl/tt_checker.sv
module tt_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic therm_gpi_i,
    input logic therm_en_i,
    input logic sw_req_i,
    input logic stpclk_no,
    input logic throttle_active_o
);

    AST_RELEASE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !throttle_active_o |=> stpclk_no); // R9

    AST_SW_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_req_i |-> throttle_active_o); // R8

    AST_GPI_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (therm_gpi_i && !sw_req_i) |-> !throttle_active_o); // R4

    AST_HW_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (throttle_active_o && !sw_req_i) |-> (therm_en_i && !therm_gpi_i)); // R5

    AST_STOP_FROM_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(stpclk_no) |-> $past(throttle_active_o)); // R1

endmodule

bind thermal_throttle_gen tt_checker i_tt_checker (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .therm_gpi_i       (therm_gpi_i),
    .therm_en_i        (therm_en_i),
    .sw_req_i          (sw_req_i),
    .stpclk_no         (stpclk_no),
    .throttle_active_o (throttle_active_o)
);

// File: tb/test_thermal_throttle_gen.sv
module test_thermal_throttle_gen;

    localparam int FINE   = 2;
    localparam int COARSE = 3;
    localparam int DW     = 4;

    typedef struct {
        logic  stp_n;
        logic  act;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, therm = 1'b0, gpi = 1'b0, hw_en = 1'b0, sw = 1'b0, csel = 1'b0;
    logic [DW-1:0] duty = '0;
    logic stp_n, act;

    // next-cycle stimulus, applied by the driver
    logic nx_therm = 1'b0, nx_gpi = 1'b0, nx_hw_en = 1'b0, nx_sw = 1'b0, nx_csel = 1'b0;
    logic [DW-1:0] nx_duty = '0;
    string cur_tag = "R10";

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    int m_state = 0; // 0 idle, 1 halt, 2 run
    int m_slot = 0, m_tcnt = 0, m_duty = 0;
    bit m_coarse = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;

    always #10 clk = ~clk;

    thermal_throttle_gen #(
        .DUTY_W       (DW),
        .FINE_TICKS   (FINE),
        .COARSE_TICKS (COARSE)
    ) i_thermal_throttle_gen (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .tick_i            (tick),
        .therm_i           (therm),
        .therm_gpi_i       (gpi),
        .therm_en_i        (hw_en),
        .sw_req_i          (sw),
        .coarse_sel_i      (csel),
        .duty_i            (duty),
        .stpclk_no         (stp_n),
        .throttle_active_o (act)
    );

    function automatic void model_edge(input bit t);
        bit a;
        int lim;
        a = sw || (hw_en && !gpi && m_s2);
        if (!a) begin
            m_state = 0; m_slot = 0; m_tcnt = 0;
        end else if (m_state == 0) begin
            m_slot = 0; m_tcnt = 0; m_duty = duty; m_coarse = csel;
            m_state = (duty != 0) ? 1 : 2;
        end else if (t) begin
            lim = m_coarse ? COARSE : FINE;
            if (m_tcnt == lim - 1) begin
                m_tcnt = 0;
                if (m_slot == 15) begin
                    m_slot = 0; m_duty = duty; m_coarse = csel;
                    m_state = (duty != 0) ? 1 : 2;
                end else begin
                    m_slot++;
                    m_state = (m_slot < m_duty) ? 1 : 2;
                end
            end else begin
                m_tcnt++;
            end
        end
        m_s2 = m_s1;
        m_s1 = therm;
    endfunction

    // driver: applies one cycle of stimulus and pushes the expected outputs
    task automatic cyc(input bit t);
        exp_t e;
        @(negedge clk);
        #2;
        tick = t; therm = nx_therm; gpi = nx_gpi; hw_en = nx_hw_en;
        sw = nx_sw; csel = nx_csel; duty = nx_duty;
        @(posedge clk);
        model_edge(t);
        #1;
        e.stp_n = (m_state != 1);
        e.act   = sw || (hw_en && !gpi && m_s2);
        e.tag   = cur_tag;
        q.push_back(e);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    // monitor: compares outputs half a period after the edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (stp_n !== e.stp_n || act !== e.act) begin
                    fails++;
                    $display("FAIL %s: stpclk_n=%b active=%b expected stpclk_n=%b active=%b at %0t",
                             e.tag, stp_n, act, e.stp_n, e.act, $time);
                end
            end
        end
    end

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        // R10: reset state
        cur_tag = "R10"; cyc(1'b0); cyc(1'b0);

        // R1 R8 R2: software request, duty 4, fine timebase
        cur_tag = "R1_R8"; nx_sw = 1'b1; nx_duty = 4'd4; nx_csel = 1'b0;
        cyc(1'b0); cyc(1'b0);
        cur_tag = "R2_R6"; ticks(2 * 16 * FINE);

        // R7: change duty and timebase mid-cycle
        ticks(5);
        cur_tag = "R7"; nx_duty = 4'd2; nx_csel = 1'b1;
        ticks(16 * FINE + 4 * COARSE);

        // R9: release, then fresh start
        cur_tag = "R9"; nx_sw = 1'b0; cyc(1'b1); cyc(1'b1); cyc(1'b0);
        nx_sw = 1'b1; nx_duty = 4'd1; nx_csel = 1'b0; cyc(1'b0); ticks(FINE + 2);
        nx_sw = 1'b0; cyc(1'b0); cyc(1'b0);

        // R3: duty zero
        cur_tag = "R3"; nx_duty = 4'd0; nx_sw = 1'b1; cyc(1'b0); ticks(16 * FINE + 4);
        nx_sw = 1'b0; cyc(1'b0);

        // R6: coarse slots, duty 3
        cur_tag = "R6"; nx_duty = 4'd3; nx_csel = 1'b1; nx_sw = 1'b1;
        cyc(1'b0); ticks(16 * COARSE + 2);
        nx_sw = 1'b0; cyc(1'b0);

        // R11 R10: thermal pin through the synchronizer
        cur_tag = "R11"; nx_hw_en = 1'b1; nx_duty = 4'd15; nx_csel = 1'b0;
        cyc(1'b0); nx_therm = 1'b1; cyc(1'b0); cyc(1'b0); cyc(1'b0); cyc(1'b0);
        cur_tag = "R2_R10"; ticks(16 * FINE);
        cur_tag = "R11"; nx_therm = 1'b0; cyc(1'b0); cyc(1'b0); cyc(1'b0); cyc(1'b0);

        // R4: pin as general-purpose input
        cur_tag = "R4"; nx_gpi = 1'b1; nx_therm = 1'b1; cyc(1'b0); ticks(10);
        // R5: hardware enable off
        cur_tag = "R5"; nx_gpi = 1'b0; nx_hw_en = 1'b0; ticks(10);
        // R8: software request with thermal blocked
        cur_tag = "R8"; nx_sw = 1'b1; nx_gpi = 1'b1; nx_duty = 4'd8; cyc(1'b0); ticks(20);
        nx_sw = 1'b0; cyc(1'b0); cyc(1'b0);

        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule